// File: doc/BRIEF.md
# 32-bit Integer Arithmetic Logic Unit

This block is the purely combinational integer execution unit of a small RISC datapath. It takes two operands and a 4-bit operation code. In the same cycle it returns a result word and three flags: all-zero, unsigned carry-out and signed overflow. It supports bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than.

Subtraction reuses the adder. Each bit slice can invert its B input, and the carry into bit 0 is forced to one, so the sum becomes A + ~B + 1. A generate/propagate carry unit supplies the carry into every slice. The signed less-than decision is the sign of A - B corrected by that subtraction's overflow. It enters the lowest slice on a dedicated input and the upper slices output zero. A branch unit can test equality by issuing a subtraction and looking at the zero flag.

Top module: `int_alu32`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of A and B.
- R2: Code 4'b0001 returns the bitwise OR of A and B.
- R3: Code 4'b0010 returns A + B modulo 2^32, with carry_out equal to the carry out of the unsigned 32-bit sum.
- R4: Code 4'b0110 returns A - B modulo 2^32, computed as A + ~B + 1, with carry_out equal to the carry of that sum (1 exactly when A >= B as unsigned numbers).
- R5: Code 4'b0111 returns 1 in bit 0 when A < B as signed two's-complement numbers and 0 otherwise, with bits 31..1 all zero. The result stays correct when A - B overflows.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every operation code.
- R7: On addition, overflow is 1 exactly when A and B have the same sign and the result sign differs from it. Operands of opposite sign never flag.
- R8: On subtraction, overflow is 1 exactly when a non-negative A minus a negative B gives a negative result, or a negative A minus a non-negative B gives a non-negative result.
- R9: For AND, OR and set-on-less-than, overflow and carry_out are both 0.
- R10: Any other operation code gives a result of all zeros with overflow and carry_out at 0, so the zero flag reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of bit 31 for add and subtract |
| overflow | output | 1 | Signed overflow for add and subtract |

## Verification
The bench aims at the signed extremes 0x7FFFFFFF and 0x80000000. A design that took its less-than bit from the raw sign of A - B would report 0x80000000 < 1 as false, and a design that compared operands without their signs would order -1 above 0x7FFFFFFF. Sums that wrap to exactly zero (0x80000000 + 0x80000000, A - A) catch overflow and carry logic that is wired to the wrong bit, and a zero flag that does not track the final result. Undefined codes and the logic operations are mixed with operands that would overflow, so a flag that leaks through its gating shows up at once.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [2:0] {
    PICK_AND  = 3'd0,
    PICK_OR   = 3'd1,
    PICK_SUM  = 3'd2,
    PICK_LESS = 3'd3,
    PICK_NONE = 3'd4
  } pick_e;

  typedef struct packed {
    logic  b_invert;    // feed ~B into the adder
    logic  carry_seed;  // carry into bit 0
    pick_e pick;        // slice output selection
    logic  arith_flags; // carry_out / overflow are reported
  } alu_ctrl_t;

  function automatic alu_ctrl_t decode_op(input logic [3:0] code);
    alu_ctrl_t c;
    c = '{b_invert: 1'b0, carry_seed: 1'b0, pick: PICK_NONE, arith_flags: 1'b0};
    case (code)
      OP_AND: c.pick = PICK_AND;
      OP_OR:  c.pick = PICK_OR;
      OP_ADD: begin
        c.pick        = PICK_SUM;
        c.arith_flags = 1'b1;
      end
      OP_SUB: begin
        c.b_invert    = 1'b1;
        c.carry_seed  = 1'b1;
        c.pick        = PICK_SUM;
        c.arith_flags = 1'b1;
      end
      OP_SLT: begin
        c.b_invert   = 1'b1;
        c.carry_seed = 1'b1;
        c.pick       = PICK_LESS;
      end
      default: ;
    endcase
    return c;
  endfunction

  // Two's-complement overflow from the sign bits of the adder inputs and sum.
  function automatic logic sign_overflow(input logic sa, input logic sb_eff, input logic ssum);
    return (sa == sb_eff) && (ssum != sa);
  endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import int_alu_pkg::*;
(
  input  logic [3:0] op_code,
  output alu_ctrl_t  ctrl
);
  always_comb ctrl = decode_op(op_code);
endmodule

// File: rtl/alu_carry_unit.sv
module alu_carry_unit #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b_eff,
  input  logic             cin,
  output logic [WIDTH:0]   carry
);
  // Carry i+1 = g_i | p_i & carry_i, evaluated from generate/propagate terms.
  function automatic logic [WIDTH:0] carries(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic c0);
    logic [WIDTH:0] c;
    c[0] = c0;
    for (int i = 0; i < WIDTH; i++) begin
      c[i+1] = (x[i] & y[i]) | ((x[i] | y[i]) & c[i]);
    end
    return c;
  endfunction

  always_comb carry = carries(a, b_eff, cin);
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import int_alu_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  logic  b_invert,
  input  logic  cin,
  input  logic  less,
  input  pick_e pick,
  output logic  sum,
  output logic  res
);
  logic b_eff;
  always_comb begin
    b_eff = b ^ b_invert;
    sum   = a ^ b_eff ^ cin;
    case (pick)
      PICK_AND:  res = a & b;
      PICK_OR:   res = a | b;
      PICK_SUM:  res = sum;
      PICK_LESS: res = less;
      default:   res = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_alu32.sv
module int_alu32
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] res_w;
  logic             adder_ovf;   // raw signed overflow of the adder
  logic             less_bit;    // corrected signed less-than

  alu_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  always_comb b_eff = op_b ^ {WIDTH{ctrl.b_invert}};

  alu_carry_unit #(.WIDTH(WIDTH)) u_carry (
    .a     (op_a),
    .b_eff (b_eff),
    .cin   (ctrl.carry_seed),
    .carry (carry)
  );

  always_comb begin
    adder_ovf = sign_overflow(op_a[MSB], b_eff[MSB], sum_w[MSB]);
    less_bit  = sum_w[MSB] ^ adder_ovf;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_low
      alu_slice u_s (
        .a        (op_a[i]),
        .b        (op_b[i]),
        .b_invert (ctrl.b_invert),
        .cin      (carry[i]),
        .less     (less_bit),
        .pick     (ctrl.pick),
        .sum      (sum_w[i]),
        .res      (res_w[i])
      );
    end else begin : g_high
      alu_slice u_s (
        .a        (op_a[i]),
        .b        (op_b[i]),
        .b_invert (ctrl.b_invert),
        .cin      (carry[i]),
        .less     (1'b0),
        .pick     (ctrl.pick),
        .sum      (sum_w[i]),
        .res      (res_w[i])
      );
    end
  end

  always_comb begin
    result    = res_w;
    zero      = ~|res_w;
    carry_out = ctrl.arith_flags & carry[WIDTH];
    overflow  = ctrl.arith_flags & adder_ovf;
  end
endmodule

// File: rtl/int_alu32_chk.sv
module int_alu32_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             carry_out,
  input logic             overflow
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R1
    and_res_chk: assert (op_code != 4'b0000 || result == (op_a & op_b));
    // R2
    or_res_chk: assert (op_code != 4'b0001 || result == (op_a | op_b));
    // R5
    slt_shape_chk: assert (op_code != 4'b0111 || result[MSB:1] == '0);
    // R7
    mixed_sign_add_chk: assert (!(op_code == 4'b0010 && op_a[MSB] != op_b[MSB]) || !overflow);
    // R8
    same_sign_sub_chk: assert (!(op_code == 4'b0110 && op_a[MSB] == op_b[MSB]) || !overflow);
    // R9
    no_flag_logic_chk: assert (!(op_code == 4'b0000 || op_code == 4'b0001 || op_code == 4'b0111)
                               || (!overflow && !carry_out));
    // R6
    equal_sub_zero_chk: assert (!(op_code == 4'b0110 && op_a == op_b) || (zero && carry_out));
    // R10
    undef_op_chk: assert (op_code == 4'b0000 || op_code == 4'b0001 || op_code == 4'b0010 ||
                          op_code == 4'b0110 || op_code == 4'b0111 ||
                          (result == '0 && zero && !overflow && !carry_out));
  end
endmodule

bind int_alu32 int_alu32_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .op_code   (op_code),
  .result    (result),
  .zero      (zero),
  .carry_out (carry_out),
  .overflow  (overflow)
);

// File: tb/sim_int_alu32.sv
`timescale 1ns/1ps
module sim_int_alu32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = 4'b0000;
  logic [31:0] result;
  logic        zero, carry_out, overflow;
  int          checks = 0, errors = 0;
  bit          timed_out = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  int_alu32 u0 (
    .op_a(a), .op_b(b), .op_code(op),
    .result(result), .zero(zero), .carry_out(carry_out), .overflow(overflow)
  );

  // Behavioural reference in wide integer arithmetic.
  logic [31:0] e_res;
  logic        e_zero, e_cout, e_ovf;
  string       tag_res, tag_cout, tag_ovf;

  task automatic model();
    logic [32:0] u;
    longint      s;
    e_res = '0; e_cout = 0; e_ovf = 0;
    tag_res = "R10"; tag_cout = "R10"; tag_ovf = "R10";
    case (op)
      4'b0000: begin e_res = a & b; tag_res = "R1"; tag_cout = "R9"; tag_ovf = "R9"; end
      4'b0001: begin e_res = a | b; tag_res = "R2"; tag_cout = "R9"; tag_ovf = "R9"; end
      4'b0010: begin
        u = {1'b0, a} + {1'b0, b};
        s = longint'($signed(a)) + longint'($signed(b));
        e_res = u[31:0]; e_cout = u[32];
        e_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        tag_res = "R3"; tag_cout = "R3"; tag_ovf = "R7";
      end
      4'b0110: begin
        e_res = a - b; e_cout = (a >= b);
        s = longint'($signed(a)) - longint'($signed(b));
        e_ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        tag_res = "R4"; tag_cout = "R4"; tag_ovf = "R8";
      end
      4'b0111: begin
        e_res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        tag_res = "R5"; tag_cout = "R9"; tag_ovf = "R9";
      end
      default: ;
    endcase
    e_zero = (e_res == 32'd0);
  endtask

  task automatic check_bit(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h op=%b actual=%0b expected=%0b", req, what, a, b, op, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] ta, logic [31:0] tb, logic [3:0] top);
    @(negedge clk);
    a = ta; b = tb; op = top;
    @(posedge clk);
    #1;
    model();
    checks++;
    if (result !== e_res) begin
      errors++;
      $display("FAIL %s result a=%h b=%h op=%b actual=%h expected=%h", tag_res, a, b, op, result, e_res);
    end
    check_bit("R6", "zero", zero, e_zero);
    check_bit(tag_cout, "carry_out", carry_out, e_cout);
    check_bit(tag_ovf, "overflow", overflow, e_ovf);
  endtask

  function automatic logic [31:0] edge_pick(int k);
    case (k % 6)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  task automatic run();
    // reset state: idle inputs, AND of zeros (R1, R6)
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== 32'd0 || zero !== 1'b1 || overflow !== 1'b0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R6 reset-state actual=%h/%0b expected=00000000/1", result, zero);
    end
    rst_n = 1'b1;
    // R1 R2
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000);
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001);
    apply(32'h0000_0000, 32'h0000_0000, 4'b0001);
    // R3 R7
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
    apply(32'h8000_0000, 32'h8000_0000, 4'b0010);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0010);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
    // R4 R8
    apply(32'h8000_0000, 32'h0000_0001, 4'b0110);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110);
    apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
    apply(32'h0000_0001, 32'h0000_0002, 4'b0110);
    // R5 with overflowing subtraction
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 4'b0111);
    apply(32'h0000_0005, 32'h0000_0005, 4'b0111);
    // R9 R10: logic/undefined with operands that would overflow
    apply(32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'b0001);
    for (int c = 0; c < 16; c++) apply(32'h8000_0000, 32'h8000_0000, c[3:0]);
    // mixed stress over all codes
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] rop;
      rop = 4'($urandom);
      if (n % 3 == 0) rop = 4'b0111;
      apply(edge_pick(n), (n % 2 == 0) ? edge_pick(n / 6) : $urandom, rop);
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule